// File: doc/BRIEF.md
# Oscillator-Fail Flag and Control Output

This block keeps the sticky status flag that tells a host whether the time base can be trusted. The flag rises whenever oscillation is missing. That happens when an external detector reports the oscillator as dead or when the host has set the stop bit. The flag then stays high until the host clears it. A clear is accepted only after the oscillator has run without a break for a qualifying number of its own cycles. That count defaults to four seconds of a 32768 Hz crystal.

The block also holds the control output bit, which drives an open-drain pin, and the stop bit. It loads the power-on values into the flag, the output bit and the stop bit. The host writes through a simple byte-wide port with a 3-bit address. The flag, stop and output bits are presented directly as outputs.

Top module: `osc_fail_ctrl`

## Requirements
- R1: While `rst` is high, at the next clock edge `fail_flag` becomes 1, `out_bit` becomes 1, `stop_bit` becomes 0 and `pin_oe` becomes 0.
- R2: When `osc_alive` is 0 at a clock edge, `fail_flag` is 1 after that edge.
- R3: A write to address 0 loads data bit 7 into `stop_bit`. When `stop_bit` is 1 at a clock edge, `fail_flag` is 1 after that edge.
- R4: Once set, `fail_flag` stays 1 at every edge that does not see an accepted clear.
- R5: A clear is a write to address 1 with data bit 7 equal to 0. It is accepted only when the run counter has already reached `RUN_TICKS` `osc_tick` pulses while the oscillator was running. Otherwise the clear is ignored.
- R6: The run counter returns to zero at any edge where `osc_alive` is 0 or `stop_bit` is 1. A clear that follows such an interruption needs a fresh full run of `RUN_TICKS` pulses.
- R7: When a set condition (R2 or R3) and a clear fall in the same cycle, the set wins and `fail_flag` is 1 afterwards.
- R8: A write to address 1 with data bit 7 equal to 1 leaves `fail_flag` unchanged. A write to any other address also leaves it unchanged.
- R9: A write to address 7 loads data bit 7 into `out_bit`. `pin_oe` is 1 exactly when `out_bit` is 0, and `pin_data` is always 0, so the pin only pulls low or floats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| osc_alive | input | 1 | Detector reports that the oscillator is running |
| osc_tick | input | 1 | One pulse per oscillator cycle |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| fail_flag | output | 1 | Sticky oscillator-fail flag |
| stop_bit | output | 1 | Oscillator stop request |
| out_bit | output | 1 | Control output bit |
| pin_oe | output | 1 | Open-drain pin enable (1 = pull low) |
| pin_data | output | 1 | Pin data value, fixed at 0 |

## Verification
A loss of oscillation and a host clear of the flag can arrive in the same cycle. The bench provokes this by letting the run counter reach its limit. It then drops `osc_alive` in the exact cycle that carries the clear write. The check is that the flag reads 1 afterwards, with the set taking priority. A second case clears after an interruption, before a fresh full run has finished. That case confirms that an earlier, partial run count is not reused.

// File: rtl/osc_fail_pkg.sv
package osc_fail_pkg;

    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 8;
    localparam int CTL_BIT = 7;

    localparam logic [ADDR_W-1:0] ADDR_STOP = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd7;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } host_wr_t;

    typedef struct packed {
        logic set_req;
        logic clr_req;
    } flag_req_t;

    function automatic logic hits(input host_wr_t w, input logic [ADDR_W-1:0] a);
        return w.en && (w.addr == a);
    endfunction

endpackage

// File: rtl/osc_ctrl_regs.sv
module osc_ctrl_regs
    import osc_fail_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  host_wr_t wr,
    output logic     stop_q,
    output logic     out_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q <= 1'b0;
            out_q  <= 1'b1;
        end else begin
            if (hits(wr, ADDR_STOP)) stop_q <= wr.data[CTL_BIT];
            if (hits(wr, ADDR_CTRL)) out_q  <= wr.data[CTL_BIT];
        end
    end
endmodule

// File: rtl/osc_run_timer.sv
module osc_run_timer #(
    parameter int RUN_TICKS = 4 * 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic halt,
    input  logic tick,
    output logic run_ok
);
    localparam int CNT_W = $clog2(RUN_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_TICKS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign run_ok = (cnt_q == LIMIT);
endmodule

// File: rtl/osc_fail_latch.sv
module osc_fail_latch
    import osc_fail_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_req_t req,
    input  logic      run_ok,
    output logic      fail_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q <= 1'b1;
        end else if (req.set_req) begin
            fail_q <= 1'b1;
        end else if (req.clr_req && run_ok) begin
            fail_q <= 1'b0;
        end
    end
endmodule

// File: rtl/osc_fail_ctrl.sv
module osc_fail_ctrl
    import osc_fail_pkg::*;
#(
    parameter int RUN_TICKS = 4 * 32768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_alive,
    input  logic              osc_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              fail_flag,
    output logic              stop_bit,
    output logic              out_bit,
    output logic              pin_oe,
    output logic              pin_data
);
    host_wr_t  wr;
    flag_req_t req;
    logic      run_ok;
    logic      no_osc;

    assign wr = '{en: wr_en, addr: wr_addr, data: wr_data};

    osc_ctrl_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .stop_q (stop_bit),
        .out_q  (out_bit)
    );

    assign no_osc = !osc_alive || stop_bit;

    osc_run_timer #(.RUN_TICKS(RUN_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .halt   (no_osc),
        .tick   (osc_tick),
        .run_ok (run_ok)
    );

    always_comb begin
        req.set_req = no_osc;
        req.clr_req = hits(wr, ADDR_FLAG) && !wr.data[CTL_BIT];
    end

    osc_fail_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .run_ok (run_ok),
        .fail_q (fail_flag)
    );

    assign pin_oe   = !out_bit;
    assign pin_data = 1'b0;
endmodule

// File: rtl/osc_fail_ctrl_chk.sv
module osc_fail_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       osc_alive,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       fail_flag,
    input logic       stop_bit,
    input logic       pin_oe,
    input logic       run_ok
);
    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == 3'd1) && !wr_data[7];

    assert_set_on_loss_R2: assert property (@(posedge clk) disable iff (rst)
        (!osc_alive || stop_bit) |=> fail_flag);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (fail_flag && !clr_wr) |=> fail_flag);

    assert_clear_qualified_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(fail_flag) |-> $past(run_ok));

    assert_run_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (!osc_alive || stop_bit) |=> !run_ok);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (!osc_alive && clr_wr) |=> fail_flag);

    assert_pin_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd7) |=> (pin_oe == !$past(wr_data[7])));
endmodule

bind osc_fail_ctrl osc_fail_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .osc_alive (osc_alive),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .fail_flag (fail_flag),
    .stop_bit  (stop_bit),
    .pin_oe    (pin_oe),
    .run_ok    (run_ok)
);

// File: tb/osc_fail_ctrl_tb.sv
module osc_fail_ctrl_tb;
    localparam int RUN = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       osc_alive, osc_tick, wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic       fail_flag, stop_bit, out_bit, pin_oe, pin_data;

    always #5 clk = ~clk;

    osc_fail_ctrl #(.RUN_TICKS(RUN)) u_dut (
        .clk(clk), .rst(rst), .osc_alive(osc_alive), .osc_tick(osc_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fail_flag(fail_flag), .stop_bit(stop_bit), .out_bit(out_bit),
        .pin_oe(pin_oe), .pin_data(pin_data)
    );

    typedef struct {
        logic  fail;
        logic  out;
        logic  stop;
        logic  oe;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    logic done   = 1'b0;

    logic m_fail, m_out, m_stop;
    int   m_cnt;

    task automatic push(input string tag);
        exp_t e;
        e.fail = m_fail; e.out = m_out; e.stop = m_stop; e.oe = !m_out; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; osc_alive = 1'b1; osc_tick = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        m_fail = 1'b1; m_out = 1'b1; m_stop = 1'b0; m_cnt = 0;
        push(tag);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input logic alive, input logic tick, input logic wen,
                        input logic [2:0] addr, input logic [7:0] data, input string tag);
        logic set_c, clr_c, qual;
        @(negedge clk);
        osc_alive = alive; osc_tick = tick;
        wr_en = wen; wr_addr = addr; wr_data = data;
        set_c = !alive || m_stop;
        clr_c = wen && addr == 3'd1 && !data[7];
        qual  = (m_cnt == RUN);
        if (set_c) m_fail = 1'b1;
        else if (clr_c && qual) m_fail = 1'b0;
        if (set_c) m_cnt = 0;
        else if (tick && m_cnt < RUN) m_cnt++;
        if (wen && addr == 3'd0) m_stop = data[7];
        if (wen && addr == 3'd7) m_out = data[7];
        push(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 1'b1, 1'b0, 3'd0, 8'h00, tag);
    endtask

    // Monitor: compares each expected item one step after the edge it describes.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_run++;
            if (fail_flag !== e.fail || out_bit !== e.out || stop_bit !== e.stop ||
                pin_oe !== e.oe || pin_data !== 1'b0) begin
                n_fail++;
                $display("FAIL %s: got fail=%b out=%b stop=%b oe=%b data=%b exp fail=%b out=%b stop=%b oe=%b data=0",
                         e.tag, fail_flag, out_bit, stop_bit, pin_oe, pin_data,
                         e.fail, e.out, e.stop, e.oe);
            end
        end
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset defaults");
        run(RUN, "R5 run up");
        step(1'b1, 1'b1, 1'b1, 3'd1, 8'h00, "R5 qualified clear");
        step(1'b1, 1'b1, 1'b1, 3'd1, 8'h80, "R8 write one to flag");
        step(1'b1, 1'b1, 1'b1, 3'd2, 8'h00, "R8 other address");
        step(1'b1, 1'b1, 1'b1, 3'd0, 8'h80, "R3 stop write");
        step(1'b1, 1'b1, 1'b0, 3'd0, 8'h00, "R3 stop sets flag");
        step(1'b1, 1'b1, 1'b1, 3'd0, 8'h00, "R3 stop release");
        run(3, "R4 sticky");
        step(1'b1, 1'b1, 1'b1, 3'd1, 8'h00, "R5 early clear ignored");
        run(RUN, "R5 run up");
        step(1'b1, 1'b1, 1'b1, 3'd1, 8'h00, "R5 clear after run");
        run(2, "R4 cleared stays");
        step(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, "R2 loss sets flag");
        run(5, "R6 partial run");
        step(1'b0, 1'b0, 1'b0, 3'd0, 8'h00, "R6 interruption");
        run(5, "R6 second partial run");
        step(1'b1, 1'b1, 1'b1, 3'd1, 8'h00, "R6 clear needs fresh run");
        run(RUN, "R6 complete run");
        step(1'b0, 1'b0, 1'b1, 3'd1, 8'h00, "R7 set beats clear");
        run(RUN + 1, "R7 recover");
        step(1'b1, 1'b1, 1'b1, 3'd1, 8'h00, "R5 clear again");
        step(1'b1, 1'b1, 1'b1, 3'd7, 8'h00, "R9 out low drives pin");
        step(1'b1, 1'b1, 1'b1, 3'd7, 8'h7F, "R9 bit7 only");
        step(1'b1, 1'b1, 1'b1, 3'd7, 8'h80, "R9 out high releases pin");
        step(1'b1, 1'b1, 1'b1, 3'd7, 8'h00, "R9 out low again");
        step(1'b1, 1'b1, 1'b1, 3'd0, 8'h80, "R3 stop with out low");
        do_reset("R1 reset from dirty state");
        step(1'b1, 1'b0, 1'b0, 3'd0, 8'h00, "R1 after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule